// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits for a short burst of up to four beats. A load edge captures a start value and the kind of access (no access, read or write) that the burst will perform. Each following advance edge moves to the next beat. The block keeps an internal beat offset and combines it with the start value. In linear order the two are added modulo four. In interleaved order they are XORed.

The order input is meant to be tied off, or changed only between bursts. A clock-enable input freezes all state when low, so a burst can be stretched with stall cycles. On continuation edges the select and write-request inputs have no effect: the burst keeps the access type captured at load time, even when the device was deselected at that load.

Top module: `burst_seq`

## Requirements
- R1: With `order_i` = 0 (linear), after k advance edges since the last load, `addr_lo_o` equals (start + k) mod 4.
- R2: With `order_i` = 1 (interleaved), after k advance edges since the last load, `addr_lo_o` equals start XOR (k mod 4).
- R3: An edge with `cke_i` = 1 and `adv_i` = 0 loads `start_i`; right after that edge `addr_lo_o` equals the loaded start value in both orders.
- R4: On a load edge `acc_o` captures the access type, encoded 2'b00 idle when `sel_i` = 0, 2'b01 read when `sel_i` = 1 and `we_i` = 0, and 2'b10 write when `sel_i` = 1 and `we_i` = 1.
- R5: On an advance edge (`cke_i` = 1, `adv_i` = 1) the values of `sel_i`, `we_i` and `start_i` are ignored, and `acc_o` keeps the type latched at the last load.
- R6: The beat offset wraps instead of saturating: after four advances `addr_lo_o` is back at the start value, and the fifth advance gives the same value as the first.
- R7: An edge with `cke_i` = 0 changes neither `addr_lo_o` nor `acc_o`, whatever the other inputs are.
- R8: While reset is asserted and after its release, until the first load, `addr_lo_o` is 2'b00 and `acc_o` is idle (2'b00).
- R9: Advance edges move the address even when the burst was loaded with `sel_i` = 0; `acc_o` stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke_i | input | 1 | Clock enable, active high; low stalls the block |
| adv_i | input | 1 | 0 loads a new start value, 1 advances the burst |
| start_i | input | 2 | Low address bits presented at a load |
| sel_i | input | 1 | Combined chip select, active high, sampled only at a load |
| we_i | input | 1 | Write request, sampled only at a load |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_lo_o | output | 2 | Current low address bits |
| acc_o | output | 2 | Latched access type: 00 idle, 01 read, 10 write |

## Verification
The embedded properties assume that `order_i` does not change inside a burst; the linear stepping property is guarded so that a change of order between bursts cannot fire it. The stimulus keeps to this assumption by setting the order only before a load. Each burst runs through every start value and access type in both orders. It advances six times with one stall inserted mid-burst. During stall and advance edges it drives the inverse of the select and write inputs and a different start value, so that any sampling of them outside a load shows up on the outputs.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_e;

  function automatic acc_e decode_acc(input logic sel, input logic we);
    if (!sel)   return ACC_IDLE;
    else if (we) return ACC_WRITE;
    else         return ACC_READ;
  endfunction

endpackage

// File: rtl/bs_rst_sync.sv
`timescale 1ns/1ps
module bs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shreg_q;
  logic [STAGES-1:0] shreg_d;

  always_comb begin
    shreg_d = {shreg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  assign rst_sync_n = shreg_q[STAGES-1];

endmodule

// File: rtl/bs_beat_ctr.sv
`timescale 1ns/1ps
module bs_beat_ctr #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_i,
  input  logic          adv_i,
  output logic [AW-1:0] beat_o
);

  logic [AW-1:0] beat_q;
  logic [AW-1:0] beat_d;

  always_comb begin
    beat_d = beat_q;
    if (cke_i) begin
      if (adv_i) beat_d = beat_q + 1'b1;
      else       beat_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  assign beat_o = beat_q;

  AST_BEAT_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_i && !adv_i) |=> (beat_o == '0)); // R3

  AST_BEAT_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_i && adv_i) |=> (beat_o == AW'($past(beat_o) + 1'b1))); // R6

  AST_BEAT_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_i |=> $stable(beat_o)); // R7

endmodule

// File: rtl/bs_load_reg.sv
`timescale 1ns/1ps
module bs_load_reg
  import burst_seq_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_i,
  input  logic          adv_i,
  input  logic [AW-1:0] start_i,
  input  logic          sel_i,
  input  logic          we_i,
  output logic [AW-1:0] start_o,
  output acc_e          acc_o
);

  logic [AW-1:0] start_q, start_d;
  acc_e          acc_q, acc_d;
  logic          load_en;

  assign load_en = cke_i && !adv_i;

  always_comb begin
    start_d = start_q;
    acc_d   = acc_q;
    if (load_en) begin
      start_d = start_i;
      acc_d   = decode_acc(sel_i, we_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      acc_q   <= ACC_IDLE;
    end else begin
      start_q <= start_d;
      acc_q   <= acc_d;
    end
  end

  assign start_o = start_q;
  assign acc_o   = acc_q;

  AST_TYPE_KEPT_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_i && adv_i) |=> $stable(acc_o)); // R5

  AST_TYPE_KEPT_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_i |=> ($stable(acc_o) && $stable(start_o))); // R7

  AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_o)); // R4

endmodule

// File: rtl/bs_addr_mix.sv
`timescale 1ns/1ps
module bs_addr_mix #(
  parameter int AW = 2
) (
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] beat_i,
  input  logic          order_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] lin_addr;
  logic [AW-1:0] ilv_addr;

  assign lin_addr = start_i + beat_i;

  for (genvar b = 0; b < AW; b++) begin : g_ilv_bit
    assign ilv_addr[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    if (order_i) addr_o = ilv_addr;
    else         addr_o = lin_addr;
  end

endmodule

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_i,
  input  logic          adv_i,
  input  logic [AW-1:0] start_i,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic          order_i,
  output logic [AW-1:0] addr_lo_o,
  output logic [1:0]    acc_o
);

  logic          rst_sync_n;
  logic [AW-1:0] beat;
  logic [AW-1:0] start_lat;
  acc_e          acc_lat;

  bs_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bs_beat_ctr #(.AW(AW)) i_beat_ctr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cke_i  (cke_i),
    .adv_i  (adv_i),
    .beat_o (beat)
  );

  bs_load_reg #(.AW(AW)) i_load_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cke_i   (cke_i),
    .adv_i   (adv_i),
    .start_i (start_i),
    .sel_i   (sel_i),
    .we_i    (we_i),
    .start_o (start_lat),
    .acc_o   (acc_lat)
  );

  bs_addr_mix #(.AW(AW)) i_addr_mix (
    .start_i (start_lat),
    .beat_i  (beat),
    .order_i (order_i),
    .addr_o  (addr_lo_o)
  );

  assign acc_o = acc_lat;

  AST_FIRST_BEAT_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cke_i && !adv_i) |=> (addr_lo_o == $past(start_i))); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cke_i && adv_i && !order_i) |=> (order_i || addr_lo_o == AW'($past(addr_lo_o) + 1'b1))); // R1

  AST_ADDR_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cke_i && $stable(order_i)) |=> (order_i != $past(order_i) || $stable(addr_lo_o))); // R7

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_sync_n |-> (addr_lo_o == '0 && acc_o == 2'b00)); // R8

endmodule

// File: tb/test_burst_seq.sv
`timescale 1ns/1ps
module test_burst_seq;

  logic       clk;
  logic       rst_n;
  logic       cke_i;
  logic       adv_i;
  logic [1:0] start_i;
  logic       sel_i;
  logic       we_i;
  logic       order_i;
  logic [1:0] addr_lo_o;
  logic [1:0] acc_o;

  int checks;
  int errors;
  bit done;

  burst_seq #(.AW(2)) i_burst_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_i     (cke_i),
    .adv_i     (adv_i),
    .start_i   (start_i),
    .sel_i     (sel_i),
    .we_i      (we_i),
    .order_i   (order_i),
    .addr_lo_o (addr_lo_o),
    .acc_o     (acc_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive after a falling edge; the rising edge captures; return on the next falling edge.
  task automatic apply(input logic cke, input logic adv, input logic [1:0] st,
                       input logic sel, input logic we);
    cke_i   = cke;
    adv_i   = adv;
    start_i = st;
    sel_i   = sel;
    we_i    = we;
    @(negedge clk);
  endtask

  function automatic int exp_addr(input int mode, input int s, input int k);
    if (mode == 0) return (s + k) % 4;
    else           return s ^ (k % 4);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; cke_i = 1'b0; adv_i = 1'b1; start_i = 2'b11;
    sel_i = 1'b1; we_i = 1'b1; order_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset addr", addr_lo_o, 0);
    check("R8 reset type", acc_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 post-reset addr", addr_lo_o, 0);
    check("R8 post-reset type", acc_o, 0);

    for (int m = 0; m < 2; m++) begin
      order_i = logic'(m);
      for (int s = 0; s < 4; s++) begin
        for (int t = 0; t < 3; t++) begin
          logic sel, we;
          sel = (t != 0);
          we  = (t == 2);
          apply(1'b1, 1'b0, 2'(s), sel, we);
          check("R3 first beat", addr_lo_o, s);
          check("R4 type at load", acc_o, t);
          for (int k = 1; k <= 6; k++) begin
            if (k == 3) begin
              apply(1'b0, 1'(k % 2), 2'((s + 1) % 4), !sel, !we);
              check("R7 stall addr", addr_lo_o, exp_addr(m, s, k - 1));
              check("R7 stall type", acc_o, t);
            end
            apply(1'b1, 1'b1, 2'(3 - s), !sel, !we);
            if (k >= 4)      check(m == 0 ? "R6 R1 linear wrap" : "R6 R2 interleaved wrap",
                                   addr_lo_o, exp_addr(m, s, k));
            else if (m == 0) check("R1 linear beat", addr_lo_o, exp_addr(m, s, k));
            else             check("R2 interleaved beat", addr_lo_o, exp_addr(m, s, k));
            if (t == 0) check("R9 idle burst type", acc_o, 0);
            else        check("R5 type kept on advance", acc_o, t);
          end
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule